// File: doc/BRIEF.md
# Cyclic Clock Multiplier Sequencer

This block is the digital sequencer of a cyclic clock multiplier that makes an output clock at M/N times a reference clock. It runs on a fast sampling clock whose period stands for one unit delay. The reference edge arrives as a one-cycle `ref_tick`, the delay ring reports each emitted pulse on `ring_pulse`, and the phase comparator result is sampled on `pd_late` (1 = output late, 0 = output early). The ring, its delay cells and the time-to-digital front end are outside the block.

After a start request the sequencer walks through four phases, one per reference period. It loads the pulse counter with M. It counts unit delays across one full reference period. It stores that count as K and enables M ring pulses per reference period. It then trims the fine delay code by one step per reference edge from the comparator result. The output divider gets the ratio N and a select saying whether the divided path is used. A new valid M or N restarts the sequence and a zero setting is refused.

Top module: `ccm_ctrl`

## Requirements
- R1: While `rst_n` is low: `k_val` = 0, `f_code` = 8, `c_val` = 0, `emit_en` = 0, `locked` = 0, `cfg_err` = 0.
- R2: A start pulse in idle enters the preset phase, where `c_val` takes M on the next cycle. The first `ref_tick` starts measurement. On the second `ref_tick`, `k_val` becomes the number of clock cycles between those two ticks, and the emit phase begins.
- R3: On entering the emit phase and at every later `ref_tick`, `c_val` is reloaded with M. Each `ring_pulse` cycle without a tick lowers it by one, and it never drops below 0. `emit_en` is 1 exactly while emitting with `c_val` nonzero.
- R4: In the tracking phase, which starts at the third `ref_tick` after start, each later `ref_tick` moves `f_code` by one: up when `pd_late` = 1 and down when it is 0.
- R5: `f_code` saturates at 15 going up and at 0 going down.
- R6: `locked` rises after three tracking ticks whose `pd_late` values alternate, which is two alternations in a row. A repeated value clears it.
- R7: A valid M or N that differs from the held setting, applied while running, sends the sequencer back to the preset phase on the next cycle. This clears `locked` and `emit_en`, updates the divider outputs, and keeps `f_code`.
- R8: M = 0 or N = 0 is refused: the held M and N do not change, no restart occurs, and `cfg_err` is 1 on the following cycle.
- R9: `div_ratio` equals the held N (1 to 8), and `div_sel` is 1 exactly when N is not 1.
- R10: `k_val` saturates at 31 when the reference period is longer than 31 cycles.
- R11: `pd_late` has no effect on `f_code` before the tracking phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, one period per unit delay |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start request, used in idle |
| ref_tick | input | 1 | One-cycle marker of a reference edge |
| ring_pulse | input | 1 | One-cycle marker of an emitted ring pulse |
| pd_late | input | 1 | Phase comparator result: 1 late, 0 early |
| m_set | input | 3 | Multiplication factor M (1 to 7) |
| n_set | input | 4 | Division factor N (1 to 8) |
| c_val | output | 5 | Pulse counter value |
| k_val | output | 5 | Captured unit-delay count K |
| f_code | output | 4 | Fine delay trim code |
| emit_en | output | 1 | Ring pulse emission enable |
| div_ratio | output | 4 | Ratio for the output divider |
| div_sel | output | 1 | Select of the divided path |
| locked | output | 1 | Lock indication |
| cfg_err | output | 1 | Refused setting flag |

## Verification
Every M from 1 to 7 is run through the full acquisition with a different reference period each time. This shows that the captured K follows the period and that emission stops after exactly M ring pulses, not one early or late. A period of 40 cycles tells saturation of K apart from wrap-around. The trim is driven with long runs of one comparator value to reach both rails, and with alternating values to separate the lock condition from a single reversal. A mid-run change of M and N, and zero settings, show the difference between a restart and a refusal.

// File: rtl/ccm_pkg.sv
package ccm_pkg;
  typedef enum logic [2:0] {
    PH_IDLE    = 3'd0,
    PH_PRESET  = 3'd1,
    PH_MEASURE = 3'd2,
    PH_EMIT    = 3'd3,
    PH_TRACK   = 3'd4
  } ccm_phase_e;
endpackage

// File: rtl/ccm_seq.sv
module ccm_seq
  import ccm_pkg::*;
#(
  parameter int M_W = 3,
  parameter int N_W = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           ref_tick,
  input  logic [M_W-1:0] m_set,
  input  logic [N_W-1:0] n_set,
  output ccm_phase_e     phase,
  output logic [M_W-1:0] m_q,
  output logic [N_W-1:0] n_q,
  output logic           restart,
  output logic           cfg_err
);
  localparam logic [M_W-1:0] M_ONE = {{(M_W-1){1'b0}}, 1'b1};
  localparam logic [N_W-1:0] N_ONE = {{(N_W-1){1'b0}}, 1'b1};

  ccm_phase_e     phase_d;
  logic [M_W-1:0] m_d;
  logic [N_W-1:0] n_d;
  logic           set_ok, set_new, err_d;

  always_comb begin
    set_ok  = (|m_set) && (|n_set);
    set_new = set_ok && ((m_set != m_q) || (n_set != n_q));
    restart = set_new && (phase != PH_IDLE);
    err_d   = !set_ok;
    m_d     = set_new ? m_set : m_q;
    n_d     = set_new ? n_set : n_q;
    phase_d = phase;
    if (restart) begin
      phase_d = PH_PRESET;
    end else begin
      case (phase)
        PH_IDLE:    if (start)    phase_d = PH_PRESET;
        PH_PRESET:  if (ref_tick) phase_d = PH_MEASURE;
        PH_MEASURE: if (ref_tick) phase_d = PH_EMIT;
        PH_EMIT:    if (ref_tick) phase_d = PH_TRACK;
        PH_TRACK:   phase_d = PH_TRACK;
        default:    phase_d = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      m_q     <= M_ONE;
      n_q     <= N_ONE;
      cfg_err <= 1'b0;
    end else begin
      phase   <= phase_d;
      m_q     <= m_d;
      n_q     <= n_d;
      cfg_err <= err_d;
    end
  end
endmodule

// File: rtl/ccm_meas.sv
module ccm_meas
  import ccm_pkg::*;
#(
  parameter int K_W = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  ccm_phase_e     phase,
  input  logic           ref_tick,
  input  logic           restart,
  output logic [K_W-1:0] k_val
);
  localparam logic [K_W-1:0] K_MAX = {K_W{1'b1}};
  localparam logic [K_W-1:0] K_INC = {{(K_W-1){1'b0}}, 1'b1};

  logic [K_W-1:0] cnt_q, cnt_d, k_d;
  logic           cnt_en, k_en;

  always_comb begin
    cnt_en = (phase == PH_MEASURE) && !ref_tick;
    k_en   = (phase == PH_MEASURE) && ref_tick && !restart;
    cnt_d  = '0;
    if (cnt_en) cnt_d = (cnt_q == K_MAX) ? K_MAX : cnt_q + K_INC;
    k_d    = k_val;
    if (k_en) k_d = (cnt_q == K_MAX) ? K_MAX : cnt_q + K_INC;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      k_val <= '0;
    end else begin
      cnt_q <= cnt_d;
      k_val <= k_d;
    end
  end
endmodule

// File: rtl/ccm_pulse.sv
module ccm_pulse
  import ccm_pkg::*;
#(
  parameter int M_W = 3,
  parameter int C_W = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  ccm_phase_e     phase,
  input  logic           ref_tick,
  input  logic           ring_pulse,
  input  logic [M_W-1:0] m_q,
  output logic [C_W-1:0] c_val,
  output logic           emit_en
);
  localparam logic [C_W-1:0] C_DEC = {{(C_W-1){1'b0}}, 1'b1};

  logic [C_W-1:0] c_d, m_ext;
  logic           emitting;

  always_comb begin
    m_ext    = C_W'(m_q);
    emitting = (phase == PH_EMIT) || (phase == PH_TRACK);
    c_d      = c_val;
    case (phase)
      PH_IDLE:    c_d = '0;
      PH_PRESET:  c_d = m_ext;
      PH_MEASURE: if (ref_tick) c_d = m_ext;
      PH_EMIT, PH_TRACK: begin
        if (ref_tick)                     c_d = m_ext;
        else if (ring_pulse && |c_val)    c_d = c_val - C_DEC;
      end
      default:    c_d = '0;
    endcase
    emit_en = emitting && (|c_val);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) c_val <= '0;
    else        c_val <= c_d;
  end
endmodule

// File: rtl/ccm_trim.sv
module ccm_trim
  import ccm_pkg::*;
#(
  parameter int F_W = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  ccm_phase_e     phase,
  input  logic           ref_tick,
  input  logic           pd_late,
  input  logic           restart,
  output logic [F_W-1:0] f_code,
  output logic           locked
);
  localparam logic [F_W-1:0] F_MAX  = {F_W{1'b1}};
  localparam logic [F_W-1:0] F_MID  = {1'b1, {(F_W-1){1'b0}}};
  localparam logic [F_W-1:0] F_STEP = {{(F_W-1){1'b0}}, 1'b1};

  logic [F_W-1:0] f_d;
  logic [1:0]     alt_q, alt_d;
  logic           have_q, have_d, prev_q, prev_d, upd;

  always_comb begin
    upd    = (phase == PH_TRACK) && ref_tick && !restart;
    f_d    = f_code;
    alt_d  = alt_q;
    have_d = have_q;
    prev_d = prev_q;
    if (upd) begin
      if (pd_late && (f_code != F_MAX))       f_d = f_code + F_STEP;
      else if (!pd_late && (f_code != '0))    f_d = f_code - F_STEP;
    end
    if (restart) begin
      alt_d  = 2'd0;
      have_d = 1'b0;
      prev_d = 1'b0;
    end else if (upd) begin
      have_d = 1'b1;
      prev_d = pd_late;
      if (!have_q)                alt_d = 2'd0;
      else if (pd_late != prev_q) alt_d = (alt_q == 2'd2) ? 2'd2 : alt_q + 2'd1;
      else                        alt_d = 2'd0;
    end
    locked = (alt_q == 2'd2);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      f_code <= F_MID;
      alt_q  <= 2'd0;
      have_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      f_code <= f_d;
      alt_q  <= alt_d;
      have_q <= have_d;
      prev_q <= prev_d;
    end
  end
endmodule

// File: rtl/ccm_ctrl.sv
module ccm_ctrl
  import ccm_pkg::*;
#(
  parameter int M_W = 3,
  parameter int N_W = 4,
  parameter int K_W = 5,
  parameter int F_W = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           ref_tick,
  input  logic           ring_pulse,
  input  logic           pd_late,
  input  logic [M_W-1:0] m_set,
  input  logic [N_W-1:0] n_set,
  output logic [K_W-1:0] c_val,
  output logic [K_W-1:0] k_val,
  output logic [F_W-1:0] f_code,
  output logic           emit_en,
  output logic [N_W-1:0] div_ratio,
  output logic           div_sel,
  output logic           locked,
  output logic           cfg_err
);
  localparam logic [N_W-1:0] N_UNITY = {{(N_W-1){1'b0}}, 1'b1};

  ccm_phase_e     phase;
  logic [M_W-1:0] m_q;
  logic [N_W-1:0] n_q;
  logic           restart;

  ccm_seq #(.M_W(M_W), .N_W(N_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .ref_tick(ref_tick),
    .m_set(m_set), .n_set(n_set), .phase(phase), .m_q(m_q), .n_q(n_q),
    .restart(restart), .cfg_err(cfg_err)
  );

  ccm_meas #(.K_W(K_W)) u_meas (
    .clk(clk), .rst_n(rst_n), .phase(phase), .ref_tick(ref_tick),
    .restart(restart), .k_val(k_val)
  );

  ccm_pulse #(.M_W(M_W), .C_W(K_W)) u_pulse (
    .clk(clk), .rst_n(rst_n), .phase(phase), .ref_tick(ref_tick),
    .ring_pulse(ring_pulse), .m_q(m_q), .c_val(c_val), .emit_en(emit_en)
  );

  ccm_trim #(.F_W(F_W)) u_trim (
    .clk(clk), .rst_n(rst_n), .phase(phase), .ref_tick(ref_tick),
    .pd_late(pd_late), .restart(restart), .f_code(f_code), .locked(locked)
  );

  always_comb begin
    div_ratio = n_q;
    div_sel   = (n_q != N_UNITY);
  end
endmodule

// File: rtl/ccm_ctrl_chk.sv
module ccm_ctrl_chk #(
  parameter int N_W = 4,
  parameter int K_W = 5,
  parameter int F_W = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           ref_tick,
  input logic           ring_pulse,
  input logic [K_W-1:0] c_val,
  input logic [K_W-1:0] k_val,
  input logic [F_W-1:0] f_code,
  input logic           emit_en,
  input logic [N_W-1:0] div_ratio,
  input logic           locked,
  input logic           cfg_err
);
  // R4: trim moves by a single step whenever it moves
  a_r4_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(f_code) |->
      (((f_code - $past(f_code)) == {{(F_W-1){1'b0}}, 1'b1}) ||
       ((f_code - $past(f_code)) == {F_W{1'b1}})));

  // R2: the captured count only moves after a reference edge
  a_r2_k_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(k_val) |-> $past(ref_tick));

  // R3: with no pulse and no tick the counter holds while emitting
  a_r3_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (emit_en && !ref_tick && !ring_pulse) |=> $stable(c_val));

  // R6: lock only appears right after a reference edge
  a_r6_lock_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(ref_tick));

  // R8: a refused setting leaves the divider ratio alone
  a_r8_refuse_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_err) |-> $stable(div_ratio));
endmodule

bind ccm_ctrl ccm_ctrl_chk #(.N_W(N_W), .K_W(K_W), .F_W(F_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .ring_pulse(ring_pulse),
  .c_val(c_val), .k_val(k_val), .f_code(f_code), .emit_en(emit_en),
  .div_ratio(div_ratio), .locked(locked), .cfg_err(cfg_err)
);

// File: tb/ccm_ctrl_tb_top.sv
module ccm_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n, start, ref_tick, ring_pulse, pd_late;
  logic [2:0] m_set;
  logic [3:0] n_set;
  logic [4:0] c_val, k_val;
  logic [3:0] f_code, div_ratio;
  logic       emit_en, div_sel, locked, cfg_err;

  int n_run  = 0;
  int n_fail = 0;
  int f_exp  = 8;
  int cyc_n  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  ccm_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .ref_tick(ref_tick),
    .ring_pulse(ring_pulse), .pd_late(pd_late), .m_set(m_set), .n_set(n_set),
    .c_val(c_val), .k_val(k_val), .f_code(f_code), .emit_en(emit_en),
    .div_ratio(div_ratio), .div_sel(div_sel), .locked(locked), .cfg_err(cfg_err)
  );

  task automatic chk(input int act, input int exp, input string tag);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  task automatic cyc(input int n, input bit ring);
    for (int i = 0; i < n; i++) begin
      ref_tick   = 1'b0;
      ring_pulse = ring;
      @(negedge clk);
    end
    ring_pulse = 1'b0;
  endtask

  task automatic tick(input bit late);
    pd_late    = late;
    ref_tick   = 1'b1;
    ring_pulse = 1'b0;
    @(negedge clk);
    ref_tick   = 1'b0;
  endtask

  task automatic trim_step(input bit late, input string tag);
    cyc(2, 1'b0);
    tick(late);
    if (late) f_exp = (f_exp < 15) ? f_exp + 1 : 15;
    else      f_exp = (f_exp > 0)  ? f_exp - 1 : 0;
    chk(f_code, f_exp, tag);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc_n++;
      if (cyc_n > 100000 && !done) begin
        n_run++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=<100000", cyc_n);
        report();
      end
    end
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; ref_tick = 1'b0; ring_pulse = 1'b0;
    pd_late = 1'b1; m_set = 3'd5; n_set = 4'd1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(k_val, 0, "R1 k");
    chk(f_code, 8, "R1 f");
    chk(c_val, 0, "R1 c");
    chk(emit_en, 0, "R1 emit");
    chk(locked, 0, "R1 lock");
    chk(cfg_err, 0, "R1 err");
    rst_n = 1'b1;
    cyc(2, 1'b0);

    // R9 divider ratio and select for every N
    for (int n = 1; n <= 8; n++) begin
      n_set = 4'(n);
      cyc(1, 1'b0);
      chk(div_ratio, n, "R9 ratio");
      chk(div_sel, (n != 1) ? 1 : 0, "R9 sel");
    end
    n_set = 4'd1;
    cyc(1, 1'b0);

    // R2 acquisition with M=5, period 7
    start = 1'b1;
    cyc(1, 1'b0);
    start = 1'b0;
    cyc(2, 1'b0);
    chk(c_val, 5, "R2 preset c");
    chk(emit_en, 0, "R2 preset emit");
    tick(1'b1);
    cyc(6, 1'b0);
    tick(1'b0);
    chk(k_val, 7, "R2 k");
    chk(emit_en, 1, "R3 emit start");
    chk(c_val, 5, "R3 load");
    chk(f_code, 8, "R11 f before tracking");
    // R3 pulse counting
    cyc(4, 1'b1);
    chk(c_val, 1, "R3 count");
    chk(emit_en, 1, "R3 emit mid");
    cyc(1, 1'b1);
    chk(emit_en, 0, "R3 emit stop");
    cyc(2, 1'b1);
    chk(c_val, 0, "R3 no underflow");
    tick(1'b1);
    chk(c_val, 5, "R3 reload");
    chk(f_code, 8, "R11 f on entry");

    // R4 / R6 trim and lock
    trim_step(1'b1, "R4 up");
    chk(locked, 0, "R6 one sample");
    trim_step(1'b0, "R4 down");
    chk(locked, 0, "R6 one alternation");
    trim_step(1'b1, "R4 up again");
    chk(locked, 1, "R6 lock");
    trim_step(1'b1, "R4 repeat");
    chk(locked, 0, "R6 unlock");
    for (int i = 0; i < 8; i++) trim_step(1'b1, "R5 top");
    chk(f_code, 15, "R5 max");
    for (int i = 0; i < 18; i++) trim_step(1'b0, "R5 bottom");
    chk(f_code, 0, "R5 min");
    trim_step(1'b1, "R4 up from 0");
    trim_step(1'b0, "R4 down to 0");
    chk(locked, 1, "R6 relock");

    // R7 restart on new setting
    m_set = 3'd3; n_set = 4'd4;
    cyc(1, 1'b0);
    chk(locked, 0, "R7 lock cleared");
    chk(emit_en, 0, "R7 emit off");
    chk(div_ratio, 4, "R7 ratio");
    chk(div_sel, 1, "R7 sel");
    chk(f_code, f_exp, "R7 f kept");
    tick(1'b1);
    cyc(39, 1'b0);
    tick(1'b1);
    chk(k_val, 31, "R10 k saturates");
    chk(c_val, 3, "R7 new M");
    chk(emit_en, 1, "R7 emit again");
    chk(f_code, f_exp, "R11 f during rerun");

    // R8 refused settings
    m_set = 3'd0;
    cyc(1, 1'b0);
    chk(cfg_err, 1, "R8 err M");
    chk(div_ratio, 4, "R8 ratio held");
    chk(emit_en, 1, "R8 no restart");
    m_set = 3'd3;
    cyc(1, 1'b0);
    chk(cfg_err, 0, "R8 err clear");
    chk(emit_en, 1, "R8 same setting");
    n_set = 4'd0;
    cyc(1, 1'b0);
    chk(cfg_err, 1, "R8 err N");
    chk(div_ratio, 4, "R8 N held");
    n_set = 4'd4;
    cyc(1, 1'b0);

    // R2 / R3 sweep over every M
    for (int m = 1; m <= 7; m++) begin
      int p;
      p = 4 + m;
      m_set = 3'(m);
      cyc(1, 1'b0);
      chk(emit_en, 0, "R7 restart sweep");
      tick(1'b0);
      cyc(p - 1, 1'b0);
      tick(1'b0);
      chk(k_val, p, "R2 sweep k");
      chk(c_val, m, "R3 sweep load");
      if (m > 1) begin
        cyc(m - 1, 1'b1);
        chk(emit_en, 1, "R3 sweep before last");
      end
      cyc(1, 1'b1);
      chk(emit_en, 0, "R3 sweep after last");
    end

    done = 1'b1;
    report();
  end
endmodule